// File: doc/BRIEF.md
# DMA Address and Word-Count Generator

This block produces the memory address for a DMA transfer and decides when the transfer is finished. It holds a working address counter and a working word counter. Each counter has a shadow register that keeps its starting value, so a transfer can be restarted without loading the values again. A 3-bit command selects one operation per cycle: write or read the mode register, read either counter, load the start address, load the count, restore both counters from their shadows, or advance by one transfer.

A 3-bit mode value sets the direction of the address counter and the condition that ends the transfer. There are four end conditions. The first is the last transfer at a word count of one. The second compares an upcounting word counter against the loaded count. The third compares the address against a target. The fourth is the borrow out of the word counter. A registered `done` flag goes high after the step that meets the selected condition. It freezes the counters until a restore or load command clears it. Bus arbitration and data movement are the job of the surrounding logic.

Top module: `dmag_top`

## Requirements
- R1: After synchronous reset the address counter, word counter, both shadows and the mode register are zero, and `done` is low.
- R2: Command 0 stores `data_in[2:0]` as the mode and ignores every higher bit. Command 1 places the mode on `data_out` with all higher bits zero. Mode bit 2 selects the address direction (1 = down, 0 = up). Mode bits 1:0 select the end condition (0 word-count-one, 1 word-count compare, 2 address compare, 3 word-counter borrow).
- R3: Command 5 loads `data_in` into the address counter and its shadow. Command 3 places the address counter on `data_out`, and `addr_out` always shows it.
- R4: Command 6 loads `data_in` into the count shadow. It also loads the working word counter with `data_in`, except in modes with bits 1:0 = 1, where the working counter starts at zero. Command 2 places the word counter on `data_out`.
- R5: Command 7 with `done` low is one step. The address moves by one in the selected direction and wraps modulo 2^16.
- R6: With mode bits 1:0 = 0, each step decrements the word counter. `done` rises after the step taken while the word counter equals 1.
- R7: With mode bits 1:0 = 1, each step increments the word counter. `done` rises after the step whose new count equals the count shadow.
- R8: With mode bits 1:0 = 2, each step decrements the word counter. `done` rises after the step whose new address equals the count shadow.
- R9: With mode bits 1:0 = 3, each step decrements the word counter. `done` rises after the step taken while the word counter is zero, and the counter wraps to all ones.
- R10: Once high, `done` stays high through other commands. While it is high, command 7 leaves the address and word counters unchanged.
- R11: Command 4 restores the address from its shadow and the word counter from its shadow (zero in modes with bits 1:0 = 1). Commands 4, 5 and 6 each clear `done`.
- R12: `data_out` is zero unless `cmd_valid` is high with a read command (1, 2 or 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd | input | 3 | Command code 0..7 |
| data_in | input | 16 | Load value for mode, address or count |
| data_out | output | 16 | Read-back value for read commands |
| addr_out | output | 16 | Current address counter |
| done | output | 1 | Transfer finished flag |

## Verification
The bench targets the end of each termination mode on the exact step.

- **Step alignment.** A design that compares after the step instead of before it would end one transfer early or late in word-count-one mode or borrow mode.
- **Address compare in down mode.** The address wraps from 0 to 0xFFFF to meet its target. An unsigned or sign mix-up there would miss the hit.
- **Compare-mode start value.** Compare mode has to start the word counter at zero after a load and after a restore. Starting it at the loaded value would never finish.
- **Stall after `done`.** Extra steps after `done` must not move the counters, and a read with the upper mode bits written must come back clean.

// File: rtl/dmag_pkg.sv
package dmag_pkg;

    localparam int MODE_BITS = 3;

    typedef enum logic [2:0] {
        CMD_WR_MODE = 3'd0,
        CMD_RD_MODE = 3'd1,
        CMD_RD_WC   = 3'd2,
        CMD_RD_ADDR = 3'd3,
        CMD_RESTORE = 3'd4,
        CMD_LD_ADDR = 3'd5,
        CMD_LD_WC   = 3'd6,
        CMD_STEP    = 3'd7
    } dmag_cmd_e;

    typedef enum logic [1:0] {
        END_WC_ONE   = 2'd0,
        END_WC_CMP   = 2'd1,
        END_ADDR_CMP = 2'd2,
        END_WC_BORROW = 2'd3
    } dmag_end_e;

    typedef struct packed {
        logic      addr_down;
        dmag_end_e end_sel;
    } dmag_mode_t;

    function automatic logic wc_counts_up(dmag_mode_t m);
        return m.end_sel == END_WC_CMP;
    endfunction

endpackage

// File: rtl/dmag_addr_ctr.sv
module dmag_addr_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         restore,
    input  logic         step,
    input  logic         down,
    input  logic [W-1:0] din,
    output logic [W-1:0] addr,
    output logic [W-1:0] addr_next
);
    logic [W-1:0] shadow_q;

    assign addr_next = down ? addr - W'(1) : addr + W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr     <= '0;
            shadow_q <= '0;
        end else if (load) begin
            addr     <= din;
            shadow_q <= din;
        end else if (restore) begin
            addr <= shadow_q;
        end else if (step) begin
            addr <= addr_next;
        end
    end

    // R5 upward step advances by one
    a_r5_step_up: assert property (@(posedge clk) disable iff (rst)
        step && !down |=> addr == $past(addr) + W'(1));
    // R5 downward step retreats by one
    a_r5_step_down: assert property (@(posedge clk) disable iff (rst)
        step && down |=> addr == $past(addr) - W'(1));
    // R11 restore brings back the saved start address
    a_r11_addr_restore: assert property (@(posedge clk) disable iff (rst)
        restore |=> addr == $past(shadow_q));
endmodule

// File: rtl/dmag_word_ctr.sv
module dmag_word_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         restore,
    input  logic         step,
    input  logic         up,
    input  logic [W-1:0] din,
    output logic [W-1:0] wc,
    output logic [W-1:0] wc_next,
    output logic [W-1:0] shadow
);
    assign wc_next = up ? wc + W'(1) : wc - W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            wc     <= '0;
            shadow <= '0;
        end else if (load) begin
            shadow <= din;
            wc     <= up ? '0 : din;
        end else if (restore) begin
            wc <= up ? '0 : shadow;
        end else if (step) begin
            wc <= wc_next;
        end
    end

    // R7 compare modes start the counter from zero
    a_r7_start_zero: assert property (@(posedge clk) disable iff (rst)
        (load || restore) && up |=> wc == '0);
    // R4 count load fills the shadow
    a_r4_shadow_load: assert property (@(posedge clk) disable iff (rst)
        load |=> shadow == $past(din));
endmodule

// File: rtl/dmag_end_detect.sv
module dmag_end_detect
    import dmag_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         clear,
    input  dmag_end_e    end_sel,
    input  logic [W-1:0] wc,
    input  logic [W-1:0] wc_next,
    input  logic [W-1:0] target,
    input  logic [W-1:0] addr_next,
    output logic         done
);
    logic hit;

    always_comb begin
        unique case (end_sel)
            END_WC_ONE:    hit = (wc == W'(1));
            END_WC_CMP:    hit = (wc_next == target);
            END_ADDR_CMP:  hit = (addr_next == target);
            END_WC_BORROW: hit = (wc == '0);
            default:       hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)              done <= 1'b0;
        else if (clear)       done <= 1'b0;
        else if (step && hit) done <= 1'b1;
    end

    // R10 done holds until a clearing command
    a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done && !clear |=> done);
    // R11 clearing commands drop done
    a_r11_clear_drops: assert property (@(posedge clk) disable iff (rst)
        clear |=> !done);
endmodule

// File: rtl/dmag_top.sv
module dmag_top
    import dmag_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cmd_valid,
    input  logic [2:0]   cmd,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] data_out,
    output logic [W-1:0] addr_out,
    output logic         done
);
    dmag_cmd_e    cmd_e;
    dmag_mode_t   mode;
    logic [MODE_BITS-1:0] mode_q;
    logic         ld_addr, ld_wc, restore, step, clear;
    logic [W-1:0] addr, addr_next, wc, wc_next, wc_shadow;

    assign cmd_e   = dmag_cmd_e'(cmd);
    assign mode    = dmag_mode_t'(mode_q);
    assign ld_addr = cmd_valid && cmd_e == CMD_LD_ADDR;
    assign ld_wc   = cmd_valid && cmd_e == CMD_LD_WC;
    assign restore = cmd_valid && cmd_e == CMD_RESTORE;
    assign step    = cmd_valid && cmd_e == CMD_STEP && !done;
    assign clear   = ld_addr || ld_wc || restore;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= '0;
        else if (cmd_valid && cmd_e == CMD_WR_MODE)
            mode_q <= data_in[MODE_BITS-1:0];
    end

    dmag_addr_ctr #(.W(W)) u_addr (
        .clk(clk), .rst(rst), .load(ld_addr), .restore(restore), .step(step),
        .down(mode.addr_down), .din(data_in), .addr(addr), .addr_next(addr_next)
    );

    dmag_word_ctr #(.W(W)) u_wc (
        .clk(clk), .rst(rst), .load(ld_wc), .restore(restore), .step(step),
        .up(wc_counts_up(mode)), .din(data_in), .wc(wc), .wc_next(wc_next),
        .shadow(wc_shadow)
    );

    dmag_end_detect #(.W(W)) u_end (
        .clk(clk), .rst(rst), .step(step), .clear(clear), .end_sel(mode.end_sel),
        .wc(wc), .wc_next(wc_next), .target(wc_shadow), .addr_next(addr_next),
        .done(done)
    );

    always_comb begin
        data_out = '0;
        if (cmd_valid) begin
            case (cmd_e)
                CMD_RD_MODE: data_out = {{(W-MODE_BITS){1'b0}}, mode_q};
                CMD_RD_WC:   data_out = wc;
                CMD_RD_ADDR: data_out = addr;
                default:     data_out = '0;
            endcase
        end
    end

    assign addr_out = addr;

    // R10 a step command while done leaves the address alone
    a_r10_frozen_addr: assert property (@(posedge clk) disable iff (rst)
        done && cmd_valid && cmd_e == CMD_STEP |=> $stable(addr_out));
    // R2 mode write takes only the low bits
    a_r2_mode_write: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_e == CMD_WR_MODE |=> mode_q == $past(data_in[MODE_BITS-1:0]));
endmodule

// File: tb/dmag_top_test.sv
module dmag_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic [15:0] data_in = 16'd0;
    logic [15:0] data_out, addr_out;
    logic        done;
    int          errors = 0;
    int          checks = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    dmag_top uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd),
        .data_in(data_in), .data_out(data_out), .addr_out(addr_out), .done(done)
    );

    // fields: req[39:36] cmd[35:33] data[32:17] expected data_out[16:1] expected done (before edge)[0]
    localparam int NV = 37;
    localparam logic [39:0] VEC [NV] = '{
        {4'd2,  3'd0, 16'hFFF8, 16'h0000, 1'b0}, // R2 mode 0, high bits ignored
        {4'd2,  3'd1, 16'h0000, 16'h0000, 1'b0}, // R2 read mode
        {4'd3,  3'd5, 16'h1000, 16'h0000, 1'b0}, // R3 load address
        {4'd4,  3'd6, 16'h0003, 16'h0000, 1'b0}, // R4 load count
        {4'd4,  3'd2, 16'h0000, 16'h0003, 1'b0}, // R4 read wc
        {4'd3,  3'd3, 16'h0000, 16'h1000, 1'b0}, // R3 read addr
        {4'd5,  3'd7, 16'h0000, 16'h0000, 1'b0}, // R5 step up
        {4'd6,  3'd7, 16'h0000, 16'h0000, 1'b0}, // R6
        {4'd6,  3'd7, 16'h0000, 16'h0000, 1'b0}, // R6 last step at wc==1
        {4'd6,  3'd3, 16'h0000, 16'h1003, 1'b1}, // R6 done after three
        {4'd10, 3'd7, 16'h0000, 16'h0000, 1'b1}, // R10 step ignored
        {4'd10, 3'd3, 16'h0000, 16'h1003, 1'b1}, // R10 addr held
        {4'd6,  3'd2, 16'h0000, 16'h0000, 1'b1}, // R6 wc reached zero
        {4'd11, 3'd4, 16'h0000, 16'h0000, 1'b1}, // R11 restore
        {4'd11, 3'd3, 16'h0000, 16'h1000, 1'b0}, // R11 addr restored
        {4'd11, 3'd2, 16'h0000, 16'h0003, 1'b0}, // R11 wc restored
        {4'd2,  3'd0, 16'h000D, 16'h0000, 1'b0}, // R2 mode 5
        {4'd2,  3'd1, 16'h0000, 16'h0005, 1'b0}, // R2 readback masked
        {4'd7,  3'd6, 16'h0002, 16'h0000, 1'b0}, // R7 load compare count
        {4'd7,  3'd2, 16'h0000, 16'h0000, 1'b0}, // R7 wc starts at zero
        {4'd5,  3'd7, 16'h0000, 16'h0000, 1'b0}, // R5 step down
        {4'd7,  3'd7, 16'h0000, 16'h0000, 1'b0}, // R7 hit
        {4'd7,  3'd2, 16'h0000, 16'h0002, 1'b1}, // R7 counted up to 2
        {4'd5,  3'd3, 16'h0000, 16'h0FFE, 1'b1}, // R5 down twice
        {4'd2,  3'd0, 16'h0006, 16'h0000, 1'b1}, // R2 mode 6, done unaffected
        {4'd11, 3'd5, 16'h0001, 16'h0000, 1'b1}, // R11 load address clears done
        {4'd4,  3'd6, 16'hFFFF, 16'h0000, 1'b0}, // R4 target FFFF
        {4'd8,  3'd7, 16'h0000, 16'h0000, 1'b0}, // R8 addr 1->0
        {4'd8,  3'd7, 16'h0000, 16'h0000, 1'b0}, // R8 addr 0->FFFF hits
        {4'd8,  3'd3, 16'h0000, 16'hFFFF, 1'b1}, // R8
        {4'd8,  3'd2, 16'h0000, 16'hFFFD, 1'b1}, // R8 wc decremented
        {4'd2,  3'd0, 16'h0003, 16'h0000, 1'b1}, // R2 mode 3
        {4'd11, 3'd6, 16'h0001, 16'h0000, 1'b1}, // R11 load count clears done
        {4'd9,  3'd7, 16'h0000, 16'h0000, 1'b0}, // R9 wc 1->0, addr wraps up
        {4'd9,  3'd7, 16'h0000, 16'h0000, 1'b0}, // R9 borrow
        {4'd9,  3'd2, 16'h0000, 16'hFFFF, 1'b1}, // R9 wc wrapped
        {4'd5,  3'd3, 16'h0000, 16'h0001, 1'b1}  // R5 wrap FFFF->0->1
    };

    function automatic string rname(input logic [3:0] n);
        case (n)
            4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
            4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
            4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
            4'd10: return "R10"; 4'd11: return "R11"; 4'd12: return "R12";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [2:0] c, input logic [15:0] d);
        @(negedge clk);
        cmd_valid = v;
        cmd = c;
        data_in = d;
        #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        check("R1 addr", addr_out, 16'h0000);
        check("R1 done", {15'd0, done}, 16'h0000);
        drive(1'b1, 3'd1, 16'h0);
        check("R1 mode", data_out, 16'h0000);
        drive(1'b1, 3'd2, 16'h0);
        check("R1 wc", data_out, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VEC[i][35:33], VEC[i][32:17]);
            check(rname(VEC[i][39:36]), data_out, VEC[i][16:1]);
            check(rname(VEC[i][39:36]), {15'd0, done}, {15'd0, VEC[i][0]});
        end

        // R12: no valid command, address nonzero, read code on cmd
        drive(1'b0, 3'd3, 16'h0);
        check("R12 idle", data_out, 16'h0000);
        check("R12 addr", addr_out, 16'h0001);

        // R6 with down direction: mode 4, one word, address wraps down
        drive(1'b1, 3'd0, 16'h0004);
        drive(1'b1, 3'd5, 16'h0000);
        drive(1'b1, 3'd6, 16'h0001);
        drive(1'b1, 3'd7, 16'h0000);
        drive(1'b0, 3'd0, 16'h0000);
        check("R6 down addr", addr_out, 16'hFFFF);
        check("R6 down done", {15'd0, done}, 16'h0001);

        // R1 reset again clears done
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #2;
        check("R1 rst done", {15'd0, done}, 16'h0000);
        check("R1 rst addr", addr_out, 16'h0000);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule